// File: doc/BRIEF.md
# Subtractive GCD Engine

The engine finds the greatest common divisor of two unsigned operands by repeated subtraction. A one-cycle `go_i` pulse while the engine is idle captures `x_i` and `y_i` into two working registers. Then, once per clock, the smaller register is subtracted from the larger one until the two are equal. That common value is written to `d_o`, and `done_o` pulses for a single cycle.

Both subtraction directions use one subtractor. An operand-swap multiplexer, steered by the less-than comparison, feeds it either (x, y) or (y, x). The controller has only two states: waiting and iterating. Each iterating cycle does useful work: a subtraction, a publish or a zero-guard exit. Every decision in a cycle uses the register values held at the start of that cycle.

A zero operand would make the loop endless. So the engine checks for it on its first iterating cycle and publishes the other operand at once; when both operands are zero it publishes zero.

Top module: `gcd_engine`

## Requirements
- R1: After reset, `d_o` is 0 and `done_o` is 0.
- R2: While the engine is idle and `go_i` is 0, `done_o` stays 0 and `d_o` does not change.
- R3: At the rising edge where the engine is idle and `go_i` is 1, the working registers take `x_i` and `y_i`. Later changes on `x_i` and `y_i` do not affect that computation.
- R4: In each iterating cycle with both registers non-zero and unequal, exactly one subtraction happens: the smaller value is subtracted from the larger one, and the difference replaces the larger one. Neither register becomes zero.
- R5: When the registers are equal, `d_o` takes their value at the next edge. The engine then returns to idle, and the result is the greatest common divisor of the operands.
- R6: `done_o` is high for exactly one cycle per result, and it is high in the same cycle that the new `d_o` first appears.
- R7: `d_o` changes only in a cycle where `done_o` is high, and it holds its value until the next result.
- R8: If either captured operand is 0, the engine publishes the other operand, or 0 if both are zero, without any subtraction. Here `done_o` is seen two cycles after the start edge.
- R9: A `go_i` pulse while a computation is running is ignored.
- R10: Latency: with n subtractions, `done_o` is seen in the cycle n+2 clock edges after the start edge, counting the start edge as 1. For (42, 8), n is 8 and the result is 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| go_i | input | 1 | Start request, sampled only while idle |
| x_i | input | W (8) | First operand |
| y_i | input | W (8) | Second operand |
| d_o | output | W (8) | Last published result |
| done_o | output | 1 | One-cycle pulse marking a new result |

## Verification
The assertions assume that each start captures settled operands, so `x_i` and `y_i` must be stable around the start edge. The bench changes inputs only on the falling clock edge, so every rising edge sees settled values. The shrink and non-zero properties rely on the zero guard having caught zero operands on the first iterating cycle. For that reason the bench deliberately starts runs with one or both operands at zero, and it also issues starts, in a separate test, while a run is under way.

// File: rtl/gcd_pkg.sv
package gcd_pkg;

    typedef enum logic {
        ST_WAIT = 1'b0,
        ST_ITER = 1'b1
    } gcd_state_e;

    typedef struct packed {
        gcd_state_e state;
    } gcd_ctrl_t;

endpackage

// File: rtl/gcd_cmp.sv
module gcd_cmp #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic         eq_o,
    output logic         lt_o,
    output logic         zero_o
);
    // Equality, less-than and any-zero flags for the two working registers
    always_comb begin
        eq_o   = (a_i == b_i);
        lt_o   = (a_i < b_i);
        zero_o = (a_i == '0) || (b_i == '0);
    end
endmodule

// File: rtl/gcd_sub.sv
module gcd_sub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         swap_i,
    output logic [W-1:0] diff_o
);
    logic [W-1:0] minuend;
    logic [W-1:0] subtrahend;

    // Operand-swap multiplexer in front of the single subtractor
    always_comb begin
        if (swap_i) begin
            minuend    = b_i;
            subtrahend = a_i;
        end else begin
            minuend    = a_i;
            subtrahend = b_i;
        end
        diff_o = minuend - subtrahend;
    end
endmodule

// File: rtl/gcd_ctrl.sv
module gcd_ctrl
    import gcd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go_i,
    input  logic eq_i,
    input  logic zero_i,
    output logic load_o,
    output logic step_o,
    output logic publish_o,
    output logic busy_o
);
    gcd_ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d    = ctrl_q;
        load_o    = 1'b0;
        step_o    = 1'b0;
        publish_o = 1'b0;
        unique case (ctrl_q.state)
            ST_WAIT: begin
                if (go_i) begin
                    load_o       = 1'b1;
                    ctrl_d.state = ST_ITER;
                end
            end
            ST_ITER: begin
                // Decisions use register values held at the start of this cycle
                if (zero_i || eq_i) begin
                    publish_o    = 1'b1;
                    ctrl_d.state = ST_WAIT;
                end else begin
                    step_o = 1'b1;
                end
            end
            default: ctrl_d.state = ST_WAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q.state <= ST_WAIT;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign busy_o = (ctrl_q.state == ST_ITER);
endmodule

// File: rtl/gcd_engine.sv
module gcd_engine #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go_i,
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    output logic [W-1:0] d_o,
    output logic         done_o
);
    typedef struct packed {
        logic [W-1:0] x;
        logic [W-1:0] y;
        logic [W-1:0] d;
        logic         done;
    } gcd_dp_t;

    gcd_dp_t dp_d, dp_q;

    logic         eq;
    logic         lt;
    logic         any_zero;
    logic         load;
    logic         step;
    logic         publish;
    logic         busy;
    logic [W-1:0] diff;
    logic [W-1:0] x_q;
    logic [W-1:0] y_q;

    assign x_q = dp_q.x;
    assign y_q = dp_q.y;

    gcd_cmp #(.W(W)) u_cmp (
        .a_i    (x_q),
        .b_i    (y_q),
        .eq_o   (eq),
        .lt_o   (lt),
        .zero_o (any_zero)
    );

    gcd_sub #(.W(W)) u_sub (
        .a_i    (x_q),
        .b_i    (y_q),
        .swap_i (lt),
        .diff_o (diff)
    );

    gcd_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .go_i      (go_i),
        .eq_i      (eq),
        .zero_i    (any_zero),
        .load_o    (load),
        .step_o    (step),
        .publish_o (publish),
        .busy_o    (busy)
    );

    always_comb begin
        dp_d      = dp_q;
        dp_d.done = 1'b0;
        if (load) begin
            dp_d.x = x_i;
            dp_d.y = y_i;
        end
        if (step) begin
            // lt picks the (y, x) orientation and writes back into y
            if (lt) begin
                dp_d.y = diff;
            end else begin
                dp_d.x = diff;
            end
        end
        if (publish) begin
            dp_d.d    = any_zero ? (x_q | y_q) : x_q;
            dp_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dp_q <= '0;
        end else begin
            dp_q <= dp_d;
        end
    end

    assign d_o    = dp_q.d;
    assign done_o = dp_q.done;
endmodule

// File: rtl/gcd_engine_chk.sv
module gcd_engine_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         done_o,
    input logic [W-1:0] d_o,
    input logic         busy,
    input logic [W-1:0] x_q,
    input logic [W-1:0] y_q
);
    logic [W:0] pair_sum;
    logic       both_live;

    assign pair_sum  = {1'b0, x_q} + {1'b0, y_q};
    assign both_live = (x_q != '0) && (y_q != '0);

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);                                                  // R6
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(d_o));                                            // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> !done_o);                                                   // R2
    AST_STEP_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && both_live && (x_q != y_q)) |=> (busy && (pair_sum < $past(pair_sum))));  // R4
    AST_STAYS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && both_live && (x_q != y_q)) |=> both_live);                   // R4
    AST_EQUAL_PUBLISH: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && both_live && (x_q == y_q)) |=> (done_o && !busy && (d_o == $past(x_q))));  // R5
    AST_ZERO_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !both_live) |=> (done_o && (d_o == ($past(x_q) | $past(y_q)))));  // R8
endmodule

bind gcd_engine gcd_engine_chk #(.W(W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .done_o (done_o),
    .d_o    (d_o),
    .busy   (busy),
    .x_q    (x_q),
    .y_q    (y_q)
);

// File: tb/gcd_engine_tb.sv
module gcd_engine_tb;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         go_i = 1'b0;
    logic [W-1:0] x_i = '0;
    logic [W-1:0] y_i = '0;
    logic [W-1:0] d_o;
    logic         done_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    // Behavioural reference, advanced on each rising edge
    int m_x = 0, m_y = 0, m_d = 0;
    bit m_run = 0, m_done = 0;

    always #4 clk = ~clk;

    gcd_engine #(.W(W)) u_dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .go_i   (go_i),
        .x_i    (x_i),
        .y_i    (y_i),
        .d_o    (d_o),
        .done_o (done_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int ref_gcd(input int a, input int b);
        int p = a, q = b, t;
        while (q != 0) begin
            t = p % q;
            p = q;
            q = t;
        end
        return p;
    endfunction

    function automatic int ref_steps(input int a, input int b);
        int p = a, q = b, n = 0;
        if (p == 0 || q == 0) return 0;
        while (p != q) begin
            if (p < q) q = q - p; else p = p - q;
            n++;
        end
        return n;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_run = 0; m_done = 0; m_d = 0;
        end else begin
            m_done = 0;
            if (!m_run) begin
                if (go_i) begin
                    m_x = int'(x_i); m_y = int'(y_i); m_run = 1;
                end
            end else if (m_x == 0 || m_y == 0) begin
                m_d = m_x + m_y; m_done = 1; m_run = 0;
            end else if (m_x == m_y) begin
                m_d = m_x; m_done = 1; m_run = 0;
            end else if (m_x < m_y) begin
                m_y = m_y - m_x;
            end else begin
                m_x = m_x - m_y;
            end
        end
    end

    // Per-cycle comparison against the reference, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check(d_o == m_d[W-1:0], "R5/R7 d_o per cycle", int'(d_o), m_d);
            check(done_o == m_done, "R6 done_o per cycle", int'(done_o), int'(m_done));
        end
    end

    // Start a run; return the cycle count until done and the result
    task automatic run_pair(input int a, input int b, output int lat, output int res);
        go_i = 1'b1; x_i = a[W-1:0]; y_i = b[W-1:0];
        lat = 0;
        @(negedge clk);
        go_i = 1'b0; lat = 1;
        while (!done_o && lat < 600) begin
            @(negedge clk);
            lat++;
        end
        res = int'(d_o);
    endtask

    initial begin
        int lat, res, hold;
        repeat (3) @(negedge clk);
        check(d_o == '0, "R1 reset d_o", int'(d_o), 0);
        check(done_o == 1'b0, "R1 reset done_o", int'(done_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: idle with go low, operands wiggling
        for (int i = 0; i < 5; i++) begin
            x_i = W'(i * 37); y_i = W'(i * 11);
            @(negedge clk);
            check(done_o == 1'b0, "R2 idle no done", int'(done_o), 0);
            check(d_o == '0, "R2 idle d_o unchanged", int'(d_o), 0);
        end

        // R10: the textbook pair
        run_pair(42, 8, lat, res);
        check(res == 2, "R10 gcd(42,8)", res, 2);
        check(lat == 10, "R10 latency for (42,8)", lat, 10);

        // R7: result holds while idle
        hold = int'(d_o);
        repeat (6) @(negedge clk);
        check(int'(d_o) == hold, "R7 d_o holds", int'(d_o), hold);
        check(done_o == 1'b0, "R6 done only one cycle", int'(done_o), 0);

        // R8: zero guard cases
        run_pair(0, 9, lat, res);
        check(res == 9, "R8 zero x", res, 9);
        check(lat == 2, "R8 zero latency", lat, 2);
        run_pair(77, 0, lat, res);
        check(res == 77, "R8 zero y", res, 77);
        run_pair(0, 0, lat, res);
        check(res == 0, "R8 both zero", res, 0);
        check(lat == 2, "R8 both zero latency", lat, 2);

        // R5: equal operands publish immediately
        run_pair(200, 200, lat, res);
        check(res == 200, "R5 equal operands", res, 200);
        check(lat == 2, "R10 equal latency", lat, 2);

        // R3 and R9: inputs and go changed during a run are ignored
        go_i = 1'b1; x_i = 8'd255; y_i = 8'd1;
        @(negedge clk);
        go_i = 1'b0; x_i = 8'd12; y_i = 8'd18;
        repeat (3) @(negedge clk);
        go_i = 1'b1;
        @(negedge clk);
        go_i = 1'b0;
        lat = 5;
        while (!done_o && lat < 600) begin
            @(negedge clk);
            lat++;
        end
        check(int'(d_o) == 1, "R3/R9 result of captured pair", int'(d_o), 1);
        check(lat == 256, "R9 latency unaffected", lat, 256);
        repeat (3) @(negedge clk);
        check(done_o == 1'b0, "R9 no second run", int'(done_o), 0);

        // R4/R5/R10: random pairs
        for (int i = 0; i < 300; i++) begin
            int a, b;
            a = int'($urandom_range(255, 1));
            b = int'($urandom_range(255, 1));
            run_pair(a, b, lat, res);
            check(res == ref_gcd(a, b), "R5 random gcd", res, ref_gcd(a, b));
            check(lat == ref_steps(a, b) + 2, "R4/R10 random latency", lat, ref_steps(a, b) + 2);
            @(negedge clk);
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule